// File: doc/BRIEF.md
# SPI Serial EEPROM Slave Engine

This block is a serial-memory target on an SPI bus in mode 0. It holds a byte-wide array, by default 256 bytes, in on-chip registers and behaves like a small serial EEPROM. Each transaction opens when chip select goes low. The first byte is a command. The command may be followed by an address and data, or it may start streaming bytes back to the host. The SPI pins are sampled in the block's own system clock domain through synchronizers. The serial clock therefore has to run several times slower than the system clock.

Write-type commands need an enable latch that the host sets first. Each such command clears the latch when it completes. A write is committed only when chip select rises exactly after the last data bit, while the serial clock is low. Before any array byte is programmed, a separate guard unit checks the target address against a two-bit protection level. After a commit, a countdown measured in system clocks models the programming time. During that time the block answers nothing except status reads.

Top module: `spi_eeprom_slave`

## Requirements
- R1: After reset the output enable is low, the status byte reads 0x00, and every array byte reads 0xFF.
- R2: The block samples serial-in on rising serial-clock edges. Serial-out changes only after falling edges. The output enable is high only while chip select is low and a reply is being shifted out.
- R3: Command 0x06 sets the write-enable latch (status bit 1). Command 0x04 clears it. Each of these commands is one byte long.
- R4: Command 0x05 shifts out the status byte MSB first and repeats it while clocks continue. The layout is: bit 0 busy, bit 1 write-enable, bits 3:2 protection level, bits 7:4 zero. While a programming cycle runs, the status byte reads 0xFF.
- R5: Command 0x03 followed by an 8-bit address (MSB first) returns the addressed byte MSB first. Serial-in is ignored once the address has been received.
- R6: A read that keeps clocking advances the address by one per byte with no gap, and wraps from 0xFF to 0x00.
- R7: Command 0x02 followed by an address and one data byte programs that byte. The commit happens only when chip select rises with exactly 24 bits clocked in and the serial clock low. A commit clears the write-enable latch and starts a busy period of PROG_CYCLES clocks.
- R8: A write whose chip select rises after 23 or 25 bits changes neither the array nor the write-enable latch.
- R9: A write with the write-enable latch clear changes nothing.
- R10: Command 0x01 followed by one byte, with the latch set and chip select rising after exactly 16 bits, loads the protection level from data bits 3:2. It ignores the other data bits, clears the latch and starts a busy period.
- R11: Protection level 1 blocks writes to 0xC0–0xFF, level 2 blocks 0x80–0xFF, and level 3 blocks every address. A blocked write leaves both the array and the write-enable latch unchanged.
- R12: While busy, every command other than 0x05 is ignored. A read produces no output enable, and 0x06 does not set the latch.
- R13: An unknown opcode is ignored until chip select rises. It produces no output and changes no status.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | SPI chip select, active low |
| sck | input | 1 | SPI serial clock, mode 0 |
| sdi | input | 1 | SPI serial data from the host |
| sdo | output | 1 | SPI serial data to the host |
| sdo_oe | output | 1 | Drive enable for sdo; high-impedance when low |

## Verification
The embedded assertions check cycle-level invariants on every clock. Serial-out moves only on a detected falling edge. The output enable never rises before a full opcode has been received. Every commit clears the enable latch and loads the busy counter. The latch stays clear and no reply other than status is driven while busy. A read pointer sitting at the top address wraps to zero. Only the bench scenarios can show the end-to-end data paths: bytes written and read back through the serial pins, the exact 24- and 16-bit commit windows against 23- and 25-bit attempts, each protection boundary, and status contents before, during and after a programming cycle.

// File: rtl/spi_ee_pkg.sv
package spi_ee_pkg;

  localparam logic [7:0] CMD_WREN = 8'h06;
  localparam logic [7:0] CMD_WRDI = 8'h04;
  localparam logic [7:0] CMD_RDSR = 8'h05;
  localparam logic [7:0] CMD_WRSR = 8'h01;
  localparam logic [7:0] CMD_READ = 8'h03;
  localparam logic [7:0] CMD_PROG = 8'h02;

  typedef enum logic [2:0] {
    OP_NONE,
    OP_RDSR,
    OP_READ,
    OP_PROG,
    OP_WRSR
  } ee_op_e;

  // True when the protection level forbids writing an address whose
  // two most significant bits are top2.
  function automatic logic addr_locked(input logic [1:0] lvl, input logic [1:0] top2);
    case (lvl)
      2'd0:    return 1'b0;
      2'd1:    return (top2 == 2'b11);
      2'd2:    return top2[1];
      default: return 1'b1;
    endcase
  endfunction

  // Status byte: busy hides everything behind all ones.
  function automatic logic [7:0] status_pack(input logic busy, input logic wel,
                                             input logic [1:0] lvl);
    return busy ? 8'hFF : {4'b0000, lvl, wel, 1'b0};
  endfunction

endpackage

// File: rtl/spi_ee_sync.sv
module spi_ee_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n,
  input  logic sck,
  input  logic sdi,
  output logic cs_act,
  output logic sck_lvl,
  output logic sdi_s,
  output logic sck_rise,
  output logic sck_fall,
  output logic cs_end
);

  logic [STAGES-1:0] cs_p, sck_p, sdi_p;
  logic              sck_prev, act_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_p     <= '1;
      sck_p    <= '0;
      sdi_p    <= '0;
      sck_prev <= 1'b0;
      act_prev <= 1'b0;
    end else begin
      cs_p     <= {cs_p[STAGES-2:0], cs_n};
      sck_p    <= {sck_p[STAGES-2:0], sck};
      sdi_p    <= {sdi_p[STAGES-2:0], sdi};
      sck_prev <= sck_p[STAGES-1];
      act_prev <= ~cs_p[STAGES-1];
    end
  end

  assign cs_act   = ~cs_p[STAGES-1];
  assign sck_lvl  = sck_p[STAGES-1];
  assign sdi_s    = sdi_p[STAGES-1];
  assign sck_rise = sck_lvl & ~sck_prev;
  assign sck_fall = ~sck_lvl & sck_prev;
  assign cs_end   = act_prev & ~cs_act;

endmodule

// File: rtl/spi_ee_guard.sv
module spi_ee_guard
  import spi_ee_pkg::*;
#(
  parameter int AW = 8
) (
  input  logic [1:0]    lvl,
  input  logic [AW-1:0] addr,
  output logic          allow
);

  assign allow = ~addr_locked(lvl, addr[AW-1 -: 2]);

endmodule

// File: rtl/spi_eeprom_slave.sv
module spi_eeprom_slave
  import spi_ee_pkg::*;
#(
  parameter int AW          = 8,
  parameter int PROG_CYCLES = 64,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n,
  input  logic sck,
  input  logic sdi,
  output logic sdo,
  output logic sdo_oe
);

  localparam int DEPTH    = 1 << AW;
  localparam int SW       = (AW > 8) ? AW : 8;
  localparam int ADDR_END = 8 + AW;
  localparam int DATA_END = ADDR_END + 8;
  localparam int SR_END   = 16;
  localparam int BCW      = $clog2(DATA_END + 2);
  localparam int CW       = $clog2(PROG_CYCLES + 1);
  localparam logic [BCW-1:0] BC_MAX = '1;

  // synchronised pin events
  logic cs_act, sck_lvl, sdi_s, sck_rise, sck_fall, cs_end;

  spi_ee_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .sdi(sdi),
    .cs_act(cs_act), .sck_lvl(sck_lvl), .sdi_s(sdi_s),
    .sck_rise(sck_rise), .sck_fall(sck_fall), .cs_end(cs_end)
  );

  logic [7:0]     mem [DEPTH];
  logic [BCW-1:0] bit_cnt;
  logic [SW-1:0]  shin;
  ee_op_e         op;
  logic [AW-1:0]  addr_q;
  logic           stream;
  logic [2:0]     obit;
  logic [7:0]     osh;
  logic           sdo_r;
  logic           wel;
  logic [1:0]     prot;
  logic [CW-1:0]  busy_cnt;

  logic [SW-1:0]  shin_next;
  logic           busy, guard_ok, commit_wr, commit_sr;
  logic [7:0]     cur_byte;

  spi_ee_guard #(.AW(AW)) u_guard (.lvl(prot), .addr(addr_q), .allow(guard_ok));

  assign shin_next = {shin[SW-2:0], sdi_s};
  assign busy      = (busy_cnt != '0);
  assign cur_byte  = (op == OP_READ) ? mem[addr_q] : status_pack(busy, wel, prot);

  // Commit windows: chip select ends with the exact bit count and clock low.
  assign commit_wr = cs_end && (op == OP_PROG) && (bit_cnt == BCW'(DATA_END))
                     && !sck_lvl && wel && guard_ok && !busy;
  assign commit_sr = cs_end && (op == OP_WRSR) && (bit_cnt == BCW'(SR_END))
                     && !sck_lvl && wel && !busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_cnt  <= '0;
      shin     <= '0;
      op       <= OP_NONE;
      addr_q   <= '0;
      stream   <= 1'b0;
      obit     <= '0;
      osh      <= '0;
      sdo_r    <= 1'b0;
      wel      <= 1'b0;
      prot     <= '0;
      busy_cnt <= '0;
    end else begin
      if (busy) busy_cnt <= busy_cnt - 1'b1;
      if (cs_act) begin
        if (sck_rise) begin
          shin <= shin_next;
          if (bit_cnt != BC_MAX) bit_cnt <= bit_cnt + 1'b1;
          if (bit_cnt == BCW'(7)) begin
            op <= OP_NONE;
            if (!busy || shin_next[7:0] == CMD_RDSR) begin
              case (shin_next[7:0])
                CMD_WREN: wel <= 1'b1;
                CMD_WRDI: wel <= 1'b0;
                CMD_RDSR: begin op <= OP_RDSR; stream <= 1'b1; obit <= '0; end
                CMD_READ: op <= OP_READ;
                CMD_PROG: op <= OP_PROG;
                CMD_WRSR: op <= OP_WRSR;
                default:  op <= OP_NONE;
              endcase
            end
          end
          if (bit_cnt == BCW'(ADDR_END - 1)) begin
            addr_q <= shin_next[AW-1:0];
            if (op == OP_READ) begin
              stream <= 1'b1;
              obit   <= '0;
            end
          end
        end
        if (sck_fall && stream) begin
          if (obit == 3'd0) begin
            sdo_r <= cur_byte[7];
            osh   <= {cur_byte[6:0], 1'b0};
          end else begin
            sdo_r <= osh[7];
            osh   <= {osh[6:0], 1'b0};
          end
          obit <= obit + 1'b1;
          if (obit == 3'd7 && op == OP_READ) addr_q <= addr_q + 1'b1;
        end
      end else begin
        bit_cnt <= '0;
        op      <= OP_NONE;
        stream  <= 1'b0;
        obit    <= '0;
      end
      if (commit_wr || commit_sr) begin
        wel      <= 1'b0;
        busy_cnt <= CW'(PROG_CYCLES);
      end
      if (commit_sr) prot <= shin[3:2];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= 8'hFF;
    end else if (commit_wr) begin
      mem[addr_q] <= shin[7:0];
    end
  end

  assign sdo    = sdo_r;
  assign sdo_oe = cs_act & stream;

  // ---------------------------------------------------------------- checks
  assert_sdo_fall_only_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !sck_fall |=> $stable(sdo_r));

  assert_oe_after_op_R2: assert property (@(posedge clk) disable iff (!rst_n)
    sdo_oe |-> (bit_cnt >= BCW'(8)));

  assert_commit_effect_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (commit_wr || commit_sr) |=> (!wel && busy_cnt == CW'(PROG_CYCLES)));

  assert_busy_nowel_R12: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !wel);

  assert_busy_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (!sdo_oe || op == OP_RDSR));

  assert_addr_wrap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (stream && op == OP_READ && sck_fall && obit == 3'd7 && addr_q == '1)
      |=> (addr_q == '0));

endmodule

// File: tb/tb_spi_eeprom_slave.sv
module tb_spi_eeprom_slave;

  localparam int PROG = 1000;
  localparam int HALF = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1;
  logic sck = 1'b0;
  logic sdi = 1'b0;
  wire  sdo, sdo_oe;

  always #2.5 clk = ~clk;

  spi_eeprom_slave #(.PROG_CYCLES(PROG)) dut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .sdi(sdi),
    .sdo(sdo), .sdo_oe(sdo_oe)
  );

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  logic [7:0] exp_q[$];
  string      tag_q[$];
  logic [7:0] act_q[$];
  logic [7:0] model [256];

  task automatic ticks(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %02h expected %02h", tag, act, exp);
    end
  endtask

  // scoreboard monitor: pairs received bytes with expected ones
  initial begin : monitor
    logic [7:0] a, e;
    string t;
    forever begin
      @(negedge clk);
      while (act_q.size() > 0) begin
        a = act_q.pop_front();
        if (exp_q.size() == 0) begin
          n_cmp++; n_bad++;
          $display("FAIL scoreboard: got %02h expected nothing", a);
        end else begin
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          chk(a, e, t);
        end
      end
    end
  end

  task automatic bits(input logic [31:0] v, input int n, output logic [31:0] rx,
                      output logic oe_and, output logic oe_or);
    rx = '0; oe_and = 1'b1; oe_or = 1'b0;
    for (int i = n - 1; i >= 0; i--) begin
      sdi = v[i];
      ticks(HALF);
      rx[i]  = sdo;
      oe_and = oe_and & sdo_oe;
      oe_or  = oe_or | sdo_oe;
      sck = 1'b1;
      ticks(HALF);
      sck = 1'b0;
    end
  endtask

  task automatic start();
    cs_n = 1'b0;
    ticks(HALF);
  endtask

  task automatic stop();
    ticks(HALF);
    cs_n = 1'b1;
    ticks(3 * HALF);
  endtask

  task automatic cmd1(input logic [7:0] c);
    logic [31:0] rx; logic oa, oo;
    start(); bits({24'd0, c}, 8, rx, oa, oo); stop();
  endtask

  task automatic rdsr(input logic [7:0] e, input int nb, input string tag);
    logic [31:0] rx; logic oa, oo;
    start();
    bits(32'h05, 8, rx, oa, oo);
    for (int k = 0; k < nb; k++) begin
      bits(32'h0, 8, rx, oa, oo);
      exp_q.push_back(e); tag_q.push_back(tag); act_q.push_back(rx[7:0]);
      chk({7'd0, oa}, 8'd1, {tag, " oe"});
    end
    stop();
  endtask

  task automatic rd(input logic [7:0] a, input int nb, input string tag);
    logic [31:0] rx; logic oa, oo;
    start();
    bits({16'd0, 8'h03, a}, 16, rx, oa, oo);
    for (int k = 0; k < nb; k++) begin
      bits(32'h0000_00A5, 8, rx, oa, oo);
      exp_q.push_back(model[8'(a + k)]); tag_q.push_back(tag); act_q.push_back(rx[7:0]);
      chk({7'd0, oa}, 8'd1, {tag, " oe"});
    end
    stop();
    chk({7'd0, sdo_oe}, 8'd0, "R2 oe released");
  endtask

  // n = 24 is a proper write; 23 or 25 shift the frame accordingly
  task automatic wr(input logic [7:0] a, input logic [7:0] d, input int n);
    logic [31:0] rx; logic oa, oo;
    start();
    bits({8'h02, a, d, 8'h00} >> (32 - n), n, rx, oa, oo);
    stop();
  endtask

  task automatic wrsr(input logic [7:0] d);
    logic [31:0] rx; logic oa, oo;
    start(); bits({16'd0, 8'h01, d}, 16, rx, oa, oo); stop();
  endtask

  task automatic settle();
    ticks(PROG + 100);
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin : watchdog
    ticks(150000);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: run hung");
      summary();
      $finish;
    end
  end

  initial begin : driver
    logic [31:0] rx; logic oa, oo;
    for (int i = 0; i < 256; i++) model[i] = 8'hFF;
    ticks(5);
    rst_n = 1'b1;
    ticks(5);

    // R1 reset state
    chk({7'd0, sdo_oe}, 8'd0, "R1 oe after reset");
    rdsr(8'h00, 1, "R1 status");
    rd(8'h10, 1, "R1 R5 erased byte");

    // R3 enable latch
    cmd1(8'h06); rdsr(8'h02, 1, "R3 wren");
    cmd1(8'h04); rdsr(8'h00, 1, "R3 wrdi");

    // R9 write without enable
    wr(8'h20, 8'h3C, 24); settle();
    rd(8'h20, 1, "R9 no enable");

    // R7 good write, R12 busy behaviour, R4 busy status
    cmd1(8'h06); wr(8'h20, 8'h3C, 24); model[8'h20] = 8'h3C;
    rdsr(8'hFF, 1, "R4 R12 busy status");
    cmd1(8'h06);
    start(); bits(32'h0320, 16, rx, oa, oo); bits(32'h0, 8, rx, oa, oo); stop();
    chk({7'd0, oo}, 8'd0, "R12 read ignored while busy");
    settle();
    rdsr(8'h00, 1, "R12 wren ignored while busy");
    rd(8'h20, 1, "R7 R5 written byte");

    // R6 continuous read with wrap
    cmd1(8'h06); wr(8'hFF, 8'h5A, 24); model[8'hFF] = 8'h5A; settle();
    cmd1(8'h06); wr(8'h00, 8'hA5, 24); model[8'h00] = 8'hA5; settle();
    rd(8'hFE, 4, "R6 wrap stream");

    // R8 wrong bit counts
    cmd1(8'h06);
    wr(8'h30, 8'h77, 23); settle();
    rdsr(8'h02, 1, "R8 23 bits keeps wel");
    wr(8'h31, 8'h77, 25); settle();
    rdsr(8'h02, 1, "R8 25 bits keeps wel");
    rd(8'h30, 2, "R8 array untouched");
    cmd1(8'h04);

    // R13 unknown opcode
    start(); bits(32'hA7, 8, rx, oa, oo); bits(32'h0, 8, rx, oa, oo); stop();
    chk({7'd0, oo}, 8'd0, "R13 no output");
    rdsr(8'h00, 1, "R13 status unchanged");

    // R10 status write, R11 protection levels
    cmd1(8'h06); wrsr(8'hF4); settle();
    rdsr(8'h04, 2, "R10 R4 level1 repeated");
    cmd1(8'h06); wr(8'hC0, 8'h11, 24); settle();
    rdsr(8'h06, 1, "R11 blocked keeps wel");
    rd(8'hC0, 1, "R11 C0 blocked");
    wr(8'hBF, 8'h11, 24); model[8'hBF] = 8'h11; settle();
    rd(8'hBF, 1, "R11 BF allowed");
    cmd1(8'h06); wrsr(8'h08); settle();
    cmd1(8'h06); wr(8'h80, 8'h22, 24); settle();
    rdsr(8'h0A, 1, "R11 level2 blocked");
    wr(8'h7F, 8'h22, 24); model[8'h7F] = 8'h22; settle();
    rd(8'h7F, 2, "R11 level2 edge");
    cmd1(8'h06); wrsr(8'h0C); settle();
    cmd1(8'h06); wr(8'h00, 8'h33, 24); settle();
    rd(8'h00, 1, "R11 level3 blocked");
    wrsr(8'h00); settle();
    rdsr(8'h00, 1, "R10 level cleared");

    ticks(20);
    if (exp_q.size() != 0) begin
      n_cmp++; n_bad++;
      $display("FAIL scoreboard: got %0d left expected 0", exp_q.size());
    end
    done = 1'b1;
    summary();
    $finish;
  end

endmodule